// File: doc/BRIEF.md
# Exception Entry and Processor Mode Controller

This block keeps the processor's current status word: condition flags, the two interrupt masks, the instruction-state bit and the five-bit mode field. It also keeps one saved status word for each exception mode. Each cycle it decides whether an exception is taken. When one is taken, it produces the handler address, a pipeline flush, a write strobe for the link register of the target bank, and the next mode, all in one step. The surrounding core supplies the return address. The core also raises `step_ok` once the instruction in execute has completed, which is the point where an exception may be taken.

The core reaches the status words through a transfer port. That port writes byte lanes of the current or saved status word, and the current privilege decides which lanes take effect. A return request reloads the current status word from the saved copy of the current mode. The `bank_sel` output tells the register file which set of banked registers to use. The register file and the pipeline stay outside this block.

Top module: `excm_ctrl`

## Requirements
- R1: After synchronous active-low reset, `cur_status` is 0x000000D3, meaning supervisor mode with both masks set and the state bit clear. In that state `bank_sel` is 3 and `pc_load` is low. The status fields are flags [31:24], I mask bit 7, F mask bit 6, state bit 5 and mode [4:0]. The mode codes are user 10000, fast 10001, irq 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111.
- R2: When an exception is taken, `pc_load`, `flush` and `lr_we` are high in that same cycle. In that cycle `lr_bank` names the target bank and `lr_value` equals `ret_addr`. From the next cycle the mode field holds the target mode, I is set, the state bit is clear and the flags are unchanged.
- R3: On entry, the saved status of the target mode receives the status word as it was before entry. While in a mode, `saved_status` shows that mode's saved copy. It reads 0 in user and system modes, which have no saved copy.
- R4: The handler addresses are undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, irq 0x18 and fast interrupt 0x1C, with the mode base at 0. Both aborts enter abort mode. The software interrupt enters supervisor mode and undefined enters undefined mode.
- R5: When requests arrive together, the one taken is data abort first, then fast interrupt, then irq, then prefetch abort, then undefined, then software interrupt.
- R6: An irq request is not taken while I is 1, and a fast request is not taken while F is 1. Fast-interrupt entry sets F. Every other entry leaves F unchanged.
- R7: No exception is taken while `step_ok` is low.
- R8: In user mode a write to the current status word changes only the flags byte. In any other mode, each byte lane whose `sw_wr_mask` bit is set is written. Mask bit 3 is the flags byte and bit 0 is the control byte.
- R9: With `sw_wr_sel` high, a write goes by lane to the saved copy of the current mode only. In user and system modes such a write has no effect.
- R10: `exc_return` in a mode that has a saved copy loads the current status word from that copy and raises `flush` in the same cycle. In user or system mode it does nothing and `flush` stays low.
- R11: `bank_sel` is 0 in user and system modes, 1 in fast, 2 in irq, 3 in supervisor, 4 in abort and 5 in undefined mode.
- R12: An exception taken in a cycle overrides a status write and a return in that cycle. A return overrides a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, the reset exception |
| step_ok | input | 1 | Instruction in execute has completed; exceptions may be taken |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| swi_req | input | 1 | Software interrupt instruction |
| und_req | input | 1 | Undefined instruction |
| pabt_req | input | 1 | Prefetch abort |
| dabt_req | input | 1 | Data abort |
| ret_addr | input | 32 | Return address for the link register |
| sw_wr_en | input | 1 | Status write strobe |
| sw_wr_sel | input | 1 | 0 writes the current status word, 1 writes the saved status word |
| sw_wr_mask | input | 4 | Byte-lane enables, bit 3 for flags and bit 0 for control |
| sw_wr_data | input | 32 | Status write data |
| exc_return | input | 1 | Restore status from the saved copy |
| pc_load | output | 1 | Load PC with `pc_vector` |
| pc_vector | output | 32 | Handler address |
| flush | output | 1 | Flush the pipeline |
| lr_we | output | 1 | Write the link register of `lr_bank` |
| lr_bank | output | 3 | Bank of the link register to write |
| lr_value | output | 32 | Value for the link register |
| bank_sel | output | 3 | Register bank selected by the current mode |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status word of the current mode |

## Verification
A wrong mode or mask bit shows one cycle after the faulty update, on `cur_status` and `bank_sel`. It also shows on the very next request, which is then taken or refused wrongly in the same cycle as the request. A wrong saved copy stays hidden until the mode it belongs to is entered again, or until a return reloads it. For that reason every entry in the bench is followed by a return, and `saved_status` and `cur_status` are compared against a model on every cycle. The sweep covers all 64 request combinations under each of the four mask settings. It is followed by directed sequences for privilege masking, saved-copy writes and same-cycle precedence.

// File: rtl/excm_pkg.sv
// Shared encodings for the exception/mode controller.
// Assumes a 32-bit status word with control bits in the low byte.
package excm_pkg;
    localparam int SW_W      = 32;
    localparam int LANES     = SW_W / 8;
    localparam int B_I       = 7;
    localparam int B_F       = 6;
    localparam int B_T       = 5;
    localparam int NUM_SAVED = 5;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef enum logic [2:0] {
        C_NONE, C_DABT, C_FIQ, C_IRQ, C_PABT, C_UND, C_SWI
    } cause_e;

    // Map a mode code to its register bank; unknown codes share the user bank.
    function automatic bank_e mode_bank(input logic [4:0] m);
        case (m)
            M_FIQ:   return BK_FIQ;
            M_IRQ:   return BK_IRQ;
            M_SVC:   return BK_SVC;
            M_ABT:   return BK_ABT;
            M_UND:   return BK_UND;
            default: return BK_USR;
        endcase
    endfunction
endpackage

// File: rtl/excm_arbiter.sv
// Picks the exception to take this cycle and its handler address and mode.
// Assumes requests are levels sampled only while step_ok is high.
module excm_arbiter
    import excm_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic        step_ok,
    input  logic        dabt,
    input  logic        fiq,
    input  logic        irq,
    input  logic        pabt,
    input  logic        und,
    input  logic        swi,
    input  logic        mask_i,
    input  logic        mask_f,
    output logic        take,
    output cause_e      cause,
    output logic [31:0] vector,
    output logic [4:0]  tmode
);
    // Fixed-priority selection among unmasked requests.
    always_comb begin
        cause = C_NONE;
        if (step_ok) begin
            if (dabt)                cause = C_DABT;
            else if (fiq && !mask_f) cause = C_FIQ;
            else if (irq && !mask_i) cause = C_IRQ;
            else if (pabt)           cause = C_PABT;
            else if (und)            cause = C_UND;
            else if (swi)            cause = C_SWI;
        end
    end

    // Handler offset and target mode for the chosen cause.
    always_comb begin
        tmode  = M_SVC;
        vector = VEC_BASE;
        case (cause)
            C_DABT: begin tmode = M_ABT; vector = VEC_BASE + 32'h10; end
            C_FIQ:  begin tmode = M_FIQ; vector = VEC_BASE + 32'h1C; end
            C_IRQ:  begin tmode = M_IRQ; vector = VEC_BASE + 32'h18; end
            C_PABT: begin tmode = M_ABT; vector = VEC_BASE + 32'h0C; end
            C_UND:  begin tmode = M_UND; vector = VEC_BASE + 32'h04; end
            C_SWI:  begin tmode = M_SVC; vector = VEC_BASE + 32'h08; end
            default: ;
        endcase
    end

    assign take = (cause != C_NONE);
endmodule

// File: rtl/excm_field_write.sv
// Merges write data into the current status word by byte lane.
// Assumes lane LANES-1 is the flags byte, the only lane writable unprivileged.
module excm_field_write
    import excm_pkg::*;
(
    input  logic [SW_W-1:0]  cur,
    input  logic [SW_W-1:0]  data,
    input  logic [LANES-1:0] mask,
    input  logic             privileged,
    output logic [SW_W-1:0]  nxt
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit USER_OK = (g == LANES - 1);
        logic lane_on;
        // Lane is written when enabled and allowed at the current privilege.
        assign lane_on = mask[g] && (privileged || USER_OK);
        assign nxt[8*g +: 8] = lane_on ? data[8*g +: 8] : cur[8*g +: 8];
    end
endmodule

// File: rtl/excm_saved_bank.sv
// One saved status word per exception bank; capture on entry, lane writes.
// Assumes bank index 0 (user/system) has no saved word and reads as zero.
module excm_saved_bank
    import excm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [2:0]       cap_idx,
    input  logic [SW_W-1:0]  cap_data,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [SW_W-1:0]  wr_data,
    input  logic [2:0]       rd_idx,
    output logic [SW_W-1:0]  rd_data
);
    logic [SW_W-1:0] regs [NUM_SAVED];

    for (genvar g = 0; g < NUM_SAVED; g++) begin : g_slot
        localparam logic [2:0] IDX = 3'(g + 1);
        // Capture wins over a lane write to the same slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (cap_en && cap_idx == IDX) begin
                regs[g] <= cap_data;
            end else if (wr_en && wr_idx == IDX) begin
                for (int b = 0; b < LANES; b++)
                    if (wr_lanes[b]) regs[g][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    // Read the slot of the requested bank.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SAVED; s++)
            if (rd_idx == 3'(s + 1)) rd_data = regs[s];
    end
endmodule

// File: rtl/excm_ctrl.sv
// Exception entry and mode controller: current status word, per-mode saved
// copies, prioritized entry, privilege-masked writes and return restore.
// Assumes the core supplies ret_addr and holds step_ok low mid-instruction.
module excm_ctrl
    import excm_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_ok,
    input  logic        irq_req,
    input  logic        fiq_req,
    input  logic        swi_req,
    input  logic        und_req,
    input  logic        pabt_req,
    input  logic        dabt_req,
    input  logic [31:0] ret_addr,
    input  logic        sw_wr_en,
    input  logic        sw_wr_sel,
    input  logic [3:0]  sw_wr_mask,
    input  logic [31:0] sw_wr_data,
    input  logic        exc_return,
    output logic        pc_load,
    output logic [31:0] pc_vector,
    output logic        flush,
    output logic        lr_we,
    output logic [2:0]  lr_bank,
    output logic [31:0] lr_value,
    output logic [2:0]  bank_sel,
    output logic [31:0] cur_status,
    output logic [31:0] saved_status
);
    localparam logic [SW_W-1:0] RESET_SW = SW_W'({1'b1, 1'b1, 1'b0, M_SVC});

    logic [SW_W-1:0] status_q;
    logic [SW_W-1:0] status_d;
    logic [SW_W-1:0] merged;
    logic [SW_W-1:0] saved_rd;
    logic            take;
    cause_e          cause;
    logic [31:0]     vector;
    logic [4:0]      tmode;
    bank_e           cur_bank;
    bank_e           tgt_bank;
    logic            privileged;
    logic            has_saved;
    logic            ret_go;
    logic            wr_go;

    assign cur_bank   = mode_bank(status_q[4:0]);
    assign tgt_bank   = mode_bank(tmode);
    assign privileged = (status_q[4:0] != M_USR);
    assign has_saved  = (cur_bank != BK_USR);
    assign ret_go     = exc_return && !take && has_saved;
    assign wr_go      = sw_wr_en && !take && !exc_return;

    excm_arbiter #(.VEC_BASE(VEC_BASE)) u_arb (
        .step_ok (step_ok),
        .dabt    (dabt_req),
        .fiq     (fiq_req),
        .irq     (irq_req),
        .pabt    (pabt_req),
        .und     (und_req),
        .swi     (swi_req),
        .mask_i  (status_q[B_I]),
        .mask_f  (status_q[B_F]),
        .take    (take),
        .cause   (cause),
        .vector  (vector),
        .tmode   (tmode)
    );

    excm_field_write u_fw (
        .cur        (status_q),
        .data       (sw_wr_data),
        .mask       (sw_wr_mask),
        .privileged (privileged),
        .nxt        (merged)
    );

    excm_saved_bank u_sav (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (take),
        .cap_idx  (tgt_bank),
        .cap_data (status_q),
        .wr_en    (wr_go && sw_wr_sel && has_saved),
        .wr_idx   (cur_bank),
        .wr_lanes (sw_wr_mask),
        .wr_data  (sw_wr_data),
        .rd_idx   (cur_bank),
        .rd_data  (saved_rd)
    );

    // Next status: entry, then return, then current-word write, else hold.
    always_comb begin
        status_d = status_q;
        if (take) begin
            status_d[4:0] = tmode;
            status_d[B_T] = 1'b0;
            status_d[B_I] = 1'b1;
            if (cause == C_FIQ) status_d[B_F] = 1'b1;
        end else if (ret_go) begin
            status_d = saved_rd;
        end else if (wr_go && !sw_wr_sel) begin
            status_d = merged;
        end
    end

    // Current status register, supervisor with masks set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= RESET_SW;
        else        status_q <= status_d;
    end

    assign pc_load      = take;
    assign pc_vector    = vector;
    assign flush        = take || ret_go;
    assign lr_we        = take;
    assign lr_bank      = tgt_bank;
    assign lr_value     = ret_addr;
    assign bank_sel     = cur_bank;
    assign cur_status   = status_q;
    assign saved_status = saved_rd;
endmodule

// File: rtl/excm_ctrl_chk.sv
// Port-level temporal checks for excm_ctrl, bound into every instance.
module excm_ctrl_chk
    import excm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        step_ok,
    input logic        pc_load,
    input logic        flush,
    input logic        lr_we,
    input logic [2:0]  lr_bank,
    input logic [2:0]  bank_sel,
    input logic [31:0] cur_status,
    input logic [31:0] saved_status
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> cur_status == 32'h0000_00D3);

    p_entry_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (flush && lr_we));

    p_entry_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |=> (cur_status[B_I] && !cur_status[B_T] && bank_sel == $past(lr_bank)));

    p_saved_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |=> saved_status == $past(cur_status));

    p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && lr_bank == BK_IRQ) |-> !cur_status[B_I]);

    p_fiq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && lr_bank == BK_FIQ) |-> !cur_status[B_F]);

    p_step_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_ok |-> !pc_load);

    p_user_flags_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_status[4:0] == M_USR && !pc_load) |=> cur_status[23:0] == $past(cur_status[23:0]));

    p_return_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !pc_load) |=> cur_status == $past(saved_status));
endmodule

bind excm_ctrl excm_ctrl_chk u_chk (.*);

// File: tb/excm_ctrl_tb.sv
module excm_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_ok = 1'b0;
    logic        irq_req = 1'b0, fiq_req = 1'b0, swi_req = 1'b0;
    logic        und_req = 1'b0, pabt_req = 1'b0, dabt_req = 1'b0;
    logic [31:0] ret_addr = '0;
    logic        sw_wr_en = 1'b0, sw_wr_sel = 1'b0;
    logic [3:0]  sw_wr_mask = '0;
    logic [31:0] sw_wr_data = '0;
    logic        exc_return = 1'b0;
    logic        pc_load, flush, lr_we;
    logic [31:0] pc_vector, lr_value, cur_status, saved_status;
    logic [2:0]  lr_bank, bank_sel;

    always #5 clk = ~clk;

    excm_ctrl u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // staged stimulus, bits of d_req: 0 irq,1 fiq,2 swi,3 und,4 pabt,5 dabt
    logic [5:0]  d_req = '0;
    logic        d_step = 1'b0, d_wen = 1'b0, d_wsel = 1'b0, d_ret = 1'b0;
    logic [3:0]  d_wmask = '0;
    logic [31:0] d_wdata = '0, d_ra = '0;

    // reference state
    logic [31:0] m_cur;
    logic [31:0] m_sav [6];

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_stage();
        d_req = '0; d_step = 0; d_wen = 0; d_wsel = 0; d_ret = 0;
        d_wmask = '0; d_wdata = '0; d_ra = '0;
    endtask

    // one cycle: drive, check all outputs against the model, advance model
    task automatic tick(input string tag);
        logic [4:0]  md;
        int          b, tb;
        logic        tk, isfiq;
        logic [4:0]  tm;
        logic [31:0] vec;
        @(negedge clk);
        irq_req = d_req[0]; fiq_req = d_req[1]; swi_req = d_req[2];
        und_req = d_req[3]; pabt_req = d_req[4]; dabt_req = d_req[5];
        step_ok = d_step; sw_wr_en = d_wen; sw_wr_sel = d_wsel;
        sw_wr_mask = d_wmask; sw_wr_data = d_wdata; exc_return = d_ret; ret_addr = d_ra;
        #1;
        md = m_cur[4:0];
        b  = bank_of(md);
        tk = 1; isfiq = 0; tm = 5'b10011; vec = 0;
        if (!d_step)                       tk = 0;
        else if (d_req[5])                 begin tm = 5'b10111; vec = 32'h10; end
        else if (d_req[1] && !m_cur[6])    begin tm = 5'b10001; vec = 32'h1C; isfiq = 1; end
        else if (d_req[0] && !m_cur[7])    begin tm = 5'b10010; vec = 32'h18; end
        else if (d_req[4])                 begin tm = 5'b10111; vec = 32'h0C; end
        else if (d_req[3])                 begin tm = 5'b11011; vec = 32'h04; end
        else if (d_req[2])                 begin tm = 5'b10011; vec = 32'h08; end
        else tk = 0;
        tb = bank_of(tm);
        chk(tag, "pc_load", {31'b0, pc_load}, {31'b0, tk});
        chk(tag, "flush", {31'b0, flush}, {31'b0, tk || (d_ret && b != 0)});
        chk(tag, "lr_we", {31'b0, lr_we}, {31'b0, tk});
        if (tk) begin
            chk(tag, "pc_vector", pc_vector, vec);
            chk(tag, "lr_bank", {29'b0, lr_bank}, 32'(tb));
            chk(tag, "lr_value", lr_value, d_ra);
        end
        chk(tag, "cur_status", cur_status, m_cur);
        chk(tag, "bank_sel", {29'b0, bank_sel}, 32'(b));
        chk(tag, "saved_status", saved_status, (b != 0) ? m_sav[b] : 32'h0);
        if (tk) begin
            m_sav[tb] = m_cur;
            m_cur[4:0] = tm;
            m_cur[5] = 0;
            m_cur[7] = 1;
            if (isfiq) m_cur[6] = 1;
        end else if (d_ret) begin
            if (b != 0) m_cur = m_sav[b];
        end else if (d_wen) begin
            for (int l = 0; l < 4; l++) begin
                if (d_wmask[l]) begin
                    if (!d_wsel && (md != 5'b10000 || l == 3)) m_cur[8*l +: 8] = d_wdata[8*l +: 8];
                    if (d_wsel && b != 0) m_sav[b][8*l +: 8] = d_wdata[8*l +: 8];
                end
            end
        end
        clear_stage();
    endtask

    task automatic set_ctrl(input string tag, input logic [7:0] ctl);
        d_wen = 1; d_wmask = 4'b0001; d_wdata = {24'h0, ctl};
        tick(tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        m_cur = 32'h0000_00D3;
        for (int i = 0; i < 6; i++) m_sav[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tick("R1");

        // R5/R6 sweep of every request set under every mask pair, with return
        for (int f = 0; f < 4; f++) begin
            for (int r = 0; r < 64; r++) begin
                set_ctrl("R8", {f[1], f[0], 1'b0, 5'b10011});
                d_req = 6'(r); d_step = 1; d_ra = 32'h1000 + 32'(r);
                tick((f[0] || f[1]) ? "R6" : "R5");
                d_ret = 1;
                tick("R2");
            end
        end

        // R4 each single cause alone, masks clear
        for (int r = 0; r < 6; r++) begin
            set_ctrl("R4", {3'b000, 5'b10011});
            d_req = 6'(1 << r); d_step = 1; d_ra = 32'hA0 + 32'(r);
            tick("R4");
            tick("R3");
            d_ret = 1;
            tick("R10");
        end

        // R7 requests held back while step_ok is low
        d_req = 6'h3F; d_step = 0;
        tick("R7");
        tick("R7");

        // R11 walk through every mode with privileged control writes
        set_ctrl("R11", 8'hD1); tick("R11");
        set_ctrl("R11", 8'hD2); tick("R11");
        set_ctrl("R11", 8'hD7); tick("R11");
        set_ctrl("R11", 8'hDB); tick("R11");
        set_ctrl("R11", 8'hDF); tick("R11");
        // R9/R10 system mode: saved write and return do nothing
        d_wen = 1; d_wsel = 1; d_wmask = 4'hF; d_wdata = 32'hDEAD_BEEF; tick("R9");
        d_ret = 1; tick("R10");
        tick("R10");
        // privileged full write in system mode, then drop to user
        d_wen = 1; d_wmask = 4'hF; d_wdata = 32'h5A3C_0F10; tick("R8");
        tick("R11");

        // R8 user: only flags lane lands
        d_wen = 1; d_wmask = 4'hF; d_wdata = 32'hF0FF_FFDF; tick("R8");
        tick("R8");
        d_wen = 1; d_wsel = 1; d_wmask = 4'hF; d_wdata = 32'h1234_5678; tick("R9");
        d_ret = 1; tick("R10");
        tick("R10");

        // back to supervisor through a software interrupt
        d_req = 6'b000100; d_step = 1; d_ra = 32'h0000_2000; tick("R4");
        tick("R3");

        // R9 write saved copy in supervisor, then return to it
        d_wen = 1; d_wsel = 1; d_wmask = 4'hF; d_wdata = 32'hA500_0011; tick("R9");
        tick("R9");
        d_ret = 1; tick("R10");
        tick("R11");
        // in fast mode, lane write to its saved copy
        d_wen = 1; d_wsel = 1; d_wmask = 4'b1001; d_wdata = 32'h7700_00D3; tick("R9");
        tick("R9");

        // R12 entry beats write and return in the same cycle
        d_req = 6'b100000; d_step = 1; d_ra = 32'h0000_3000;
        d_wen = 1; d_wmask = 4'hF; d_wdata = 32'h0; d_ret = 1;
        tick("R12");
        tick("R12");
        // return beats write
        d_ret = 1; d_wen = 1; d_wmask = 4'hF; d_wdata = 32'hFFFF_FFFF;
        tick("R12");
        tick("R12");
        // R6 fast entry from fast mode with F clear, then irq with I clear
        set_ctrl("R6", 8'h11);
        d_req = 6'b000011; d_step = 1; d_ra = 32'h44; tick("R6");
        tick("R6");
        set_ctrl("R6", 8'h12);
        d_req = 6'b000001; d_step = 1; d_ra = 32'h48; tick("R6");
        tick("R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule